// File: doc/BRIEF.md
# Condition flags and branch decision unit

This block keeps the four processor status flags (negative, zero, signed overflow, carry) and turns a 4-bit branch condition code into a taken or not-taken decision. The flags come from one of two sources. The first is an 8-bit addition of two operands, which the block performs itself so that it can see the carry out. The second is a 16-bit register load value, which changes N and Z, clears V and leaves C alone.

An execution controller pulses `upd_valid` for one cycle with `upd_mode` and the operands to change the flags. A branch stage puts a condition code on `cond_sel` and reads `taken` one cycle later. The sixteen codes form eight complementary pairs: each odd code is the exact inverse of the even code below it. The pairs cover unconditional, single-flag, unsigned-magnitude and signed-magnitude tests.

Top module: `ccr_branch_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, all four flags and `taken` read 0.
- R2: On an add update (`upd_mode`=0), N becomes bit 7 of the 8-bit sum and Z becomes 1 exactly when the 8-bit sum is zero (for example $10+$F0 gives Z=1, N=0).
- R3: On an add update, C becomes the carry out of bit 7 ($10+$F0 and $90+$90 both give C=1).
- R4: On an add update, V becomes 1 exactly when both operands have the same sign bit and the sum's sign bit differs ($90+$90 gives V=1, N=0, Z=0). Operands of opposite sign never give V=1.
- R5: On a load update (`upd_mode`=1), N becomes bit 15 of `load_val`, Z becomes 1 exactly when all 16 bits are zero, and V becomes 0. C keeps its previous value. For example, $9000 gives N=1, Z=0, V=0.
- R6: In a cycle with `upd_valid` low, the flags keep their values whatever the operands and mode are.
- R7: Single-flag codes: 0 is always taken and 1 is never taken. 6 is taken when Z=0 and 7 when Z=1. 4 is taken when C=0 and 5 when C=1. 8 is taken when V=0 and 9 when V=1. 10 is taken when N=0 and 11 when N=1.
- R8: Unsigned codes: 2 is taken when C and Z are both 0, and 3 is taken when C or Z is 1.
- R9: Signed codes: 12 is taken when N xor V = 0, and 13 when N xor V = 1. 14 is taken when Z=0 and N xor V = 0. 15 is taken when Z=1 or N xor V = 1.
- R10: For every flag state, the decision for an odd code is the inverse of the decision for the even code one below it.
- R11: `taken` is registered. At each rising edge it takes the decision for the `cond_sel` present before that edge, evaluated against the flags held before that edge. A flag update at the same edge is seen only from the next evaluation onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | One-cycle flag update strobe |
| upd_mode | input | 1 | 0 = add operands, 1 = 16-bit load value |
| add_a | input | 8 | First add operand |
| add_b | input | 8 | Second add operand |
| load_val | input | 16 | Value moved by a 16-bit load |
| cond_sel | input | 4 | Branch condition code |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry flag |
| taken | output | 1 | Registered branch decision |

## Verification
A corrupted flag bit shows on its flag output at the first sampling point after the edge that caused it. It then stays wrong until the next update, because the flags are the block's only state. The same fault reaches `taken` one edge later, for every code that reads that flag. For this reason the bench sweeps all sixteen codes over flag states that separate the pairs. A wrong carry that a load should have kept, or a slip in pair inversion, shows up only under particular flag states. Those states are built on purpose: Z with C, V without N, N with C, and a load that follows a carry.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_flags_t;

  typedef enum logic {
    UPD_ADD  = 1'b0,
    UPD_LOAD = 1'b1
  } upd_mode_t;

  localparam int COND_W = 4;

endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIDE_W = 16
) (
  input  upd_mode_t             mode,
  input  logic [DATA_W-1:0]     op_a,
  input  logic [DATA_W-1:0]     op_b,
  input  logic [WIDE_W-1:0]     wide_val,
  input  ccr_flags_t            cur,
  output ccr_flags_t            nxt
);

  localparam int SUM_W = DATA_W + 1;
  localparam int MSB   = DATA_W - 1;
  localparam int WMSB  = WIDE_W - 1;

  logic [SUM_W-1:0]  sum_ext;
  logic [DATA_W-1:0] sum;
  ccr_flags_t        add_f;
  ccr_flags_t        load_f;

  always_comb begin
    sum_ext = {1'b0, op_a} + {1'b0, op_b};
    sum     = sum_ext[DATA_W-1:0];
    add_f.n = sum[MSB];
    add_f.z = (sum == '0);
    add_f.c = sum_ext[DATA_W];
    add_f.v = (op_a[MSB] & op_b[MSB] & ~sum[MSB]) |
              (~op_a[MSB] & ~op_b[MSB] & sum[MSB]);
  end

  always_comb begin
    load_f.n = wide_val[WMSB];
    load_f.z = (wide_val == '0);
    load_f.v = 1'b0;
    load_f.c = cur.c;
  end

  assign nxt = (mode == UPD_LOAD) ? load_f : add_f;

endmodule

// File: rtl/ccr_flag_reg.sv
module ccr_flag_reg
  import ccr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_valid,
  input  ccr_flags_t nxt,
  output ccr_flags_t flags
);

  always_ff @(posedge clk) begin
    if (rst)            flags <= '0;
    else if (upd_valid) flags <= nxt;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(flags))
    else $error("flags moved without an update strobe (R6)");

endmodule

// File: rtl/ccr_cond_eval.sv
module ccr_cond_eval
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] sel,
  input  ccr_flags_t        flags,
  output logic              taken
);

  logic sgn_lt;
  logic base;
  logic decision;

  always_comb begin
    sgn_lt = flags.n ^ flags.v;
    unique case (sel[COND_W-1:1])
      3'd0: base = 1'b1;
      3'd1: base = ~(flags.c | flags.z);
      3'd2: base = ~flags.c;
      3'd3: base = ~flags.z;
      3'd4: base = ~flags.v;
      3'd5: base = ~flags.n;
      3'd6: base = ~sgn_lt;
      default: base = ~(flags.z | sgn_lt);
    endcase
    decision = base ^ sel[0];
  end

  always_ff @(posedge clk) begin
    if (rst) taken <= 1'b0;
    else     taken <= decision;
  end

  p_always_r7: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'h0) |=> taken)
    else $error("code 0 not taken (R7)");

  p_never_r7: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'h1) |=> !taken)
    else $error("code 1 taken (R7)");

  p_eq_r7: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'h7 && flags.z) |=> taken)
    else $error("equal test missed with Z set (R7)");

  p_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'h2 && flags.c) |=> !taken)
    else $error("higher taken with carry set (R8)");

endmodule

// File: rtl/ccr_branch_unit.sv
module ccr_branch_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIDE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic              upd_mode,
  input  logic [DATA_W-1:0] add_a,
  input  logic [DATA_W-1:0] add_b,
  input  logic [WIDE_W-1:0] load_val,
  input  logic [3:0]        cond_sel,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              taken
);

  localparam int MSB = DATA_W - 1;

  ccr_flags_t flags_q;
  ccr_flags_t flags_nxt;
  upd_mode_t  mode;

  assign mode = upd_mode_t'(upd_mode);

  ccr_flag_calc #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_calc (
    .mode     (mode),
    .op_a     (add_a),
    .op_b     (add_b),
    .wide_val (load_val),
    .cur      (flags_q),
    .nxt      (flags_nxt)
  );

  ccr_flag_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .nxt       (flags_nxt),
    .flags     (flags_q)
  );

  ccr_cond_eval u_eval (
    .clk   (clk),
    .rst   (rst),
    .sel   (cond_sel),
    .flags (flags_q),
    .taken (taken)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_mode && add_a != '0 && DATA_W'(add_a + add_b) == '0)
      |=> (flag_z && flag_c))
    else $error("wrap to zero lacks Z or C (R3)");

  p_mixed_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_mode && (add_a[MSB] != add_b[MSB])) |=> !flag_v)
    else $error("overflow from mixed-sign add (R4)");

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_mode) |=> (!flag_v && flag_c == $past(flag_c)))
    else $error("load touched V or C wrongly (R5)");

endmodule

// File: tb/ccr_branch_unit_bench.sv
module ccr_branch_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        upd_valid;
  logic        upd_mode;
  logic [7:0]  add_a;
  logic [7:0]  add_b;
  logic [15:0] load_val;
  logic [3:0]  cond_sel;
  logic        flag_n, flag_z, flag_v, flag_c, taken;

  always #10 clk = ~clk;

  ccr_branch_unit u_ccr_branch_unit (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_mode(upd_mode),
    .add_a(add_a), .add_b(add_b), .load_val(load_val), .cond_sel(cond_sel),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .taken(taken)
  );

  typedef struct {
    logic [3:0] nzvc;
    logic       tk;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  logic m_n = 0, m_z = 0, m_v = 0, m_c = 0;

  function automatic logic ref_taken(input logic [3:0] s);
    case (s)
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return !m_c && !m_z;
      4'h3: return m_c || m_z;
      4'h4: return !m_c;
      4'h5: return m_c;
      4'h6: return !m_z;
      4'h7: return m_z;
      4'h8: return !m_v;
      4'h9: return m_v;
      4'hA: return !m_n;
      4'hB: return m_n;
      4'hC: return (m_n == m_v);
      4'hD: return (m_n != m_v);
      4'hE: return !m_z && (m_n == m_v);
      default: return m_z || (m_n != m_v);
    endcase
  endfunction

  function automatic string sel_tag(input logic [3:0] s);
    if (s == 4'h2 || s == 4'h3) return "R8 R10 R11";
    if (s >= 4'hC)              return "R9 R10 R11";
    return "R7 R10 R11";
  endfunction

  task automatic do_op(input logic upd, input logic mode, input logic [7:0] a,
                       input logic [7:0] b, input logic [15:0] lv,
                       input logic [3:0] s, input string tag);
    exp_t e;
    int   sa, sb, ss;
    logic [8:0] sum;
    @(negedge clk);
    upd_valid = upd; upd_mode = mode; add_a = a; add_b = b;
    load_val = lv; cond_sel = s;
    e.tk = ref_taken(s);
    if (upd) begin
      if (!mode) begin
        sum = {1'b0, a} + {1'b0, b};
        sa = a[7] ? int'(a) - 256 : int'(a);
        sb = b[7] ? int'(b) - 256 : int'(b);
        ss = sa + sb;
        m_n = sum[7];
        m_z = (sum[7:0] == 8'h00);
        m_c = sum[8];
        m_v = (ss > 127) || (ss < -128);
      end else begin
        m_n = lv[15];
        m_z = (lv == 16'h0000);
        m_v = 1'b0;
      end
    end
    e.nzvc = {m_n, m_z, m_v, m_c};
    e.tag  = tag;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tests++;
        if ({flag_n, flag_z, flag_v, flag_c} !== e.nzvc || taken !== e.tk) begin
          fails++;
          $display("FAIL %s: nzvc=%b taken=%b expected nzvc=%b taken=%b",
                   e.tag, {flag_n, flag_z, flag_v, flag_c}, taken, e.nzvc, e.tk);
        end
      end
    end
  end

  task automatic sweep(input string why);
    for (int s = 0; s < 16; s++)
      do_op(1'b0, 1'b0, 8'hA5, 8'h5A, 16'h0000, 4'(s), {sel_tag(4'(s)), " ", why});
  endtask

  initial begin : watchdog
    #(20 * 20000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    rst = 1'b1; upd_valid = 0; upd_mode = 0; add_a = 0; add_b = 0;
    load_val = 0; cond_sel = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if ({flag_n, flag_z, flag_v, flag_c, taken} !== 5'b0) begin
      fails++;
      $display("FAIL R1: got %b expected 00000", {flag_n, flag_z, flag_v, flag_c, taken});
    end
    rst = 1'b0;
    #1;
    tests++;
    if ({flag_n, flag_z, flag_v, flag_c, taken} !== 5'b0) begin
      fails++;
      $display("FAIL R1: after release got %b expected 00000",
               {flag_n, flag_z, flag_v, flag_c, taken});
    end

    // R11: update and EQ test at same edge sees old Z=0
    do_op(1'b1, 1'b0, 8'h10, 8'hF0, 16'h0, 4'h7, "R2 R3 R4 R11 10+F0");
    sweep("Z,C");
    do_op(1'b1, 1'b0, 8'h90, 8'h90, 16'h0, 4'h0, "R2 R3 R4 90+90");
    sweep("V,C");
    do_op(1'b1, 1'b1, 8'h00, 8'h00, 16'h9000, 4'h1, "R5 load 9000 keeps C");
    sweep("N,C");
    do_op(1'b1, 1'b0, 8'h7F, 8'h01, 16'h0, 4'h0, "R2 R3 R4 7F+01");
    sweep("N,V");
    do_op(1'b1, 1'b0, 8'h40, 8'h10, 16'h0, 4'h0, "R2 R3 R4 40+10");
    sweep("clear");
    do_op(1'b1, 1'b0, 8'h80, 8'h80, 16'h0, 4'h0, "R2 R3 R4 80+80");
    do_op(1'b1, 1'b1, 8'h00, 8'h00, 16'h0000, 4'h0, "R5 load 0000 keeps C");
    sweep("Z,C after load");
    do_op(1'b1, 1'b0, 8'hF0, 8'h10, 16'h0, 4'h0, "R3 R4 F0+10");
    do_op(1'b1, 1'b0, 8'h01, 8'h02, 16'h0, 4'h0, "R3 no carry 01+02");
    do_op(1'b1, 1'b1, 8'h00, 8'h00, 16'h7FFF, 4'h0, "R5 load 7FFF keeps C=0");
    do_op(1'b0, 1'b0, 8'hFF, 8'h01, 16'h0, 4'h7, "R6 no strobe add");
    do_op(1'b0, 1'b1, 8'h00, 8'h00, 16'h8000, 4'hB, "R6 no strobe load");
    do_op(1'b1, 1'b0, 8'hC0, 8'h40, 16'h0, 4'h5, "R2 R3 C0+40");
    do_op(1'b1, 1'b0, 8'h00, 8'h00, 16'h0, 4'h5, "R3 R11 old C seen");

    @(negedge clk);
    upd_valid = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule